// File: doc/BRIEF.md
# Remote Wake-Up Power Sequencer

This block decides the power state of the far end of a serial video link. It watches the byte stream from the control-channel receiver, a write port into its own control register, and a clock-lock indication. From these it drives an analog-wake enable, a flag saying the control channel may carry configuration traffic, and a flag saying the link is serializing. A strap input picks the mode. In local mode the block comes up configured and serializes once the clock has been stable long enough. In remote mode it sleeps until a dedicated wake byte arrives. It then lets the analog circuits settle. After that it opens a bounded window in which the host must clear the power-down bit, or it falls back asleep.

The settle and window durations are derived from a clock-frequency parameter in kHz, and the lock qualification length is a cycle count parameter. The control register sits at address 4. Bit 4 is power-down and bit 3 is serialization enable. Writes reach it only while the control channel is ready.

Top module: `rwk_seq_top`

## Requirements
- R1: While reset is asserted the state is LOW_POWER, with power-down 1, serialization enable 0 and all three status outputs low. With `remote_strap_i` = 0 the first clock edge after reset release moves the block to CONTROL_OPEN with power-down 0 and serialization enable 1.
- R2: With `remote_strap_i` = 1 the block stays in LOW_POWER after reset, with `analog_wake_o` low, until a wake byte arrives.
- R3: In LOW_POWER, a received byte of value 0xDB (`rx_valid_i` high) moves the block to SETTLE at that clock edge and raises `analog_wake_o`. Any other byte value leaves it in LOW_POWER.
- R4: `cc_ready_o` stays low for SETTLE_CYC clock cycles after the edge that took the wake byte. At edge SETTLE_CYC after it, the block enters CONFIG_WINDOW and `cc_ready_o` rises.
- R5: A register write (`wr_en_i`) takes effect only at address 4 and only while `cc_ready_o` is high. Bit 4 of the data is power-down and bit 3 is serialization enable. Writes in LOW_POWER, SETTLE or SERIALIZING, and writes to any other address, change nothing.
- R6: If no write with bit 4 = 0 lands by edge WINDOW_CYC after the wake-byte edge, the block returns to LOW_POWER at that edge with power-down 1 and serialization enable 0. A clearing write sampled on that same edge still counts.
- R7: A write with bit 4 = 0 during CONFIG_WINDOW moves the block to CONTROL_OPEN with power-down 0 and enable taken from bit 3. CONTROL_OPEN never times out while enable is 0.
- R8: A write with bit 4 = 1 while `cc_ready_o` is high returns the block to LOW_POWER at that edge, with power-down 1 and enable 0.
- R9: From CONTROL_OPEN the block enters SERIALIZING at the first edge where enable is already 1 and `lock_i` has been sampled high on that edge and on the LOCK_CYC edges before it. A low sample restarts the count.
- R10: In SERIALIZING, `ser_active_o` is high and `cc_ready_o` is low. A low `lock_i` returns the block to CONTROL_OPEN at that edge.
- R11: `state_o` encodes LOW_POWER=0, SETTLE=1, CONFIG_WINDOW=2, CONTROL_OPEN=3, SERIALIZING=4. `analog_wake_o` is high in every state except LOW_POWER, and `cc_ready_o` is high exactly in states 2 and 3.
- R12: A wake byte received outside LOW_POWER has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| remote_strap_i | input | 1 | 1 = remote wake-up mode, 0 = local power-up mode |
| rx_valid_i | input | 1 | Strobe: a received control-channel byte is present |
| rx_byte_i | input | 8 | Received byte value |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 8 | Register write data |
| lock_i | input | 1 | Clock lock indication |
| analog_wake_o | output | 1 | Analog circuitry enable |
| cc_ready_o | output | 1 | Control channel accepts configuration |
| ser_active_o | output | 1 | Serialization running |
| pd_o | output | 1 | Power-down register bit |
| ser_en_o | output | 1 | Serialization enable register bit |
| state_o | output | 3 | Current state, debug |

## Verification
Every internal state of this block is visible within one cycle on `state_o`, the register bits and the three status flags. A wrong state or register transition therefore shows at the next sampling point. The timers differ. A settle or window counter that runs off by one only shows at the edge where `cc_ready_o` should rise or the block should fall asleep. That can be up to WINDOW_CYC cycles after the wake byte, so the bench compares a reference model on every cycle and also probes those exact boundary edges, including a clearing write on the final window edge. A faulty lock qualifier shows as SERIALIZING one edge early or late, or as a missing restart after a lock glitch.

// File: rtl/rwk_pkg.sv
package rwk_pkg;
  typedef enum logic [2:0] {
    ST_LOW    = 3'd0,
    ST_SETTLE = 3'd1,
    ST_CFG    = 3'd2,
    ST_OPEN   = 3'd3,
    ST_SER    = 3'd4
  } rwk_state_e;

  localparam logic [7:0] WAKE_BYTE = 8'hDB;
  localparam int unsigned ADDR_W    = 4;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 4'd4;
  localparam int unsigned PD_BIT    = 4;
  localparam int unsigned SEREN_BIT = 3;
endpackage

// File: rtl/rwk_lock_timer.sv
module rwk_lock_timer #(
  parameter int unsigned LOCK_CYC = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  output logic stable_o
);
  localparam int unsigned CW = $clog2(LOCK_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(LOCK_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!lock_i)     cnt_q <= '0;
    else if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
  end

  assign stable_o = (cnt_q == CMAX);

  assert_lock_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |=> !stable_o);
endmodule

// File: rtl/rwk_elapsed.sv
module rwk_elapsed #(
  parameter int unsigned SETTLE_CYC = 20000,
  parameter int unsigned WINDOW_CYC = 14000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic settle_done_o,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(WINDOW_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WINDOW_CYC - 1);
  localparam logic [CW-1:0] SLAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (run_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign settle_done_o = (cnt_q == SLAST);
  assign expire_o      = (cnt_q == LAST);
endmodule

// File: rtl/rwk_ctrl_reg.sv
module rwk_ctrl_reg
  import rwk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_local_i,
  input  logic       force_lp_i,
  input  logic       wr_i,
  input  logic [7:0] wr_data_i,
  output logic       pd_o,
  output logic       ser_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_o     <= 1'b1;
      ser_en_o <= 1'b0;
    end else if (set_local_i) begin
      pd_o     <= 1'b0;
      ser_en_o <= 1'b1;
    end else if (force_lp_i) begin
      pd_o     <= 1'b1;
      ser_en_o <= 1'b0;
    end else if (wr_i) begin
      pd_o     <= wr_data_i[PD_BIT];
      ser_en_o <= wr_data_i[SEREN_BIT];
    end
  end

  assert_force_lp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_lp_i |=> (pd_o && !ser_en_o));
endmodule

// File: rtl/rwk_seq_top.sv
module rwk_seq_top
  import rwk_pkg::*;
#(
  parameter int unsigned CLK_KHZ   = 200000,
  parameter int unsigned SETTLE_US = 100,
  parameter int unsigned WINDOW_MS = 70,
  parameter int unsigned LOCK_CYC  = 32768
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              remote_strap_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_byte_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              lock_i,
  output logic              analog_wake_o,
  output logic              cc_ready_o,
  output logic              ser_active_o,
  output logic              pd_o,
  output logic              ser_en_o,
  output logic [2:0]        state_o
);
  localparam int unsigned SETTLE_CYC = (CLK_KHZ * SETTLE_US) / 1000;
  localparam int unsigned WINDOW_CYC = CLK_KHZ * WINDOW_MS;

  rwk_state_e state_q, state_d;
  logic boot_q;
  logic wake_hit, wr_hit, pd_req, pd_clear;
  logic settle_done, expire, lock_ok;
  logic set_local, force_lp;

  assign cc_ready_o    = (state_q == ST_CFG) || (state_q == ST_OPEN);
  assign analog_wake_o = (state_q != ST_LOW);
  assign ser_active_o  = (state_q == ST_SER);
  assign state_o       = state_q;

  assign wake_hit = rx_valid_i && (rx_byte_i == WAKE_BYTE);
  assign wr_hit   = wr_en_i && (wr_addr_i == CTRL_ADDR) && cc_ready_o;
  assign pd_req   = wr_hit && wr_data_i[PD_BIT];
  assign pd_clear = wr_hit && !wr_data_i[PD_BIT];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_LOW: begin
        if (!boot_q && !remote_strap_i) state_d = ST_OPEN;
        else if (wake_hit)              state_d = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (expire)           state_d = ST_LOW;
        else if (settle_done) state_d = ST_CFG;
      end
      ST_CFG: begin
        if (pd_req)        state_d = ST_LOW;
        else if (pd_clear) state_d = ST_OPEN;
        else if (expire)   state_d = ST_LOW;
      end
      ST_OPEN: begin
        if (pd_req)                              state_d = ST_LOW;
        else if (ser_en_o && lock_ok && lock_i)  state_d = ST_SER;
      end
      ST_SER: if (!lock_i) state_d = ST_OPEN;
      default: state_d = ST_LOW;
    endcase
  end

  assign set_local = (state_q == ST_LOW) && !boot_q && !remote_strap_i;
  assign force_lp  = (state_q != ST_LOW) && (state_d == ST_LOW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOW;
      boot_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      boot_q  <= 1'b1;
    end
  end

  rwk_elapsed #(
    .SETTLE_CYC(SETTLE_CYC),
    .WINDOW_CYC(WINDOW_CYC)
  ) u_elapsed (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clr_i         ((state_q == ST_LOW) && (state_d == ST_SETTLE)),
    .run_i         ((state_q == ST_SETTLE) || (state_q == ST_CFG)),
    .settle_done_o (settle_done),
    .expire_o      (expire)
  );

  rwk_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lock_i   (lock_i),
    .stable_o (lock_ok)
  );

  rwk_ctrl_reg u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_local_i (set_local),
    .force_lp_i  (force_lp),
    .wr_i        (wr_hit && !pd_req),
    .wr_data_i   (wr_data_i),
    .pd_o        (pd_o),
    .ser_en_o    (ser_en_o)
  );

  assert_wake_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOW && !wake_hit) |=> (state_q != ST_SETTLE));

  assert_window_expiry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CFG && expire && !pd_clear) |=> (state_q == ST_LOW));

  assert_open_pd_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OPEN) |-> !pd_o);

  assert_ser_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SER) |-> (ser_en_o && !pd_o));

  assert_cfg_after_settle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETTLE && !settle_done) |=> (state_q != ST_CFG));
endmodule

// File: tb/sim_rwk_seq_top.sv
module sim_rwk_seq_top;
  localparam int CLK_KHZ = 100, SETTLE_US = 100, WINDOW_MS = 1, LOCK = 16;
  localparam int SET = CLK_KHZ * SETTLE_US / 1000;  // 10
  localparam int WIN = CLK_KHZ * WINDOW_MS;         // 100

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b1;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic lock = 1'b0;
  logic wake_o, ready_o, ser_o, pd_o, se_o;
  logic [2:0] st_o;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rwk_seq_top #(.CLK_KHZ(CLK_KHZ), .SETTLE_US(SETTLE_US), .WINDOW_MS(WINDOW_MS), .LOCK_CYC(LOCK)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .remote_strap_i(strap), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .lock_i(lock),
    .analog_wake_o(wake_o), .cc_ready_o(ready_o), .ser_active_o(ser_o),
    .pd_o(pd_o), .ser_en_o(se_o), .state_o(st_o));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_st, m_el, m_lk;
  bit m_pd, m_se, m_boot;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_el = 0; m_lk = 0; m_pd = 1; m_se = 0; m_boot = 0;
    end else begin
      int ns;
      bit rdy, wr, old_se, lk_ok;
      ns = m_st;
      rdy = (m_st == 2 || m_st == 3);
      wr = wr_en && wr_addr == 4 && rdy;
      old_se = m_se;
      lk_ok = (m_lk >= LOCK);
      case (m_st)
        0: if (!m_boot && !strap) begin ns = 3; m_pd = 0; m_se = 1; end
           else if (rx_valid && rx_byte == 8'hDB) begin ns = 1; end
        1: if (m_el == SET - 1) ns = 2;
        2: if (wr && wr_data[4]) ns = 0;
           else if (wr) begin ns = 3; m_pd = 0; m_se = wr_data[3]; end
           else if (m_el == WIN - 1) ns = 0;
        3: if (wr && wr_data[4]) ns = 0;
           else begin
             if (wr) m_se = wr_data[3];
             if (old_se && lk_ok && lock) ns = 4;
           end
        default: if (!lock) ns = 3;
      endcase
      if (m_st == 0 && ns == 1) m_el = 0;
      else if ((m_st == 1 || m_st == 2) && m_el < WIN - 1) m_el++;
      if (ns == 0 && m_st != 0) begin m_pd = 1; m_se = 0; end
      m_lk = lock ? ((m_lk < LOCK) ? m_lk + 1 : LOCK) : 0;
      m_boot = 1;
      m_st = ns;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk("R11 model state", int'(st_o), m_st);
      chk("R11 model wake", int'(wake_o), int'(m_st != 0));
      chk("R4 model ready", int'(ready_o), int'(m_st == 2 || m_st == 3));
      chk("R10 model ser", int'(ser_o), int'(m_st == 4));
      chk("R5 model pd", int'(pd_o), int'(m_pd));
      chk("R5 model seren", int'(se_o), int'(m_se));
    end
  end

  task automatic send_byte(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic write_reg(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=0", cycles);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk("R1 reset state", int'(st_o), 0);
    chk("R1 reset pd", int'(pd_o), 1);
    chk("R1 reset seren", int'(se_o), 0);
    chk("R1 reset flags", int'({wake_o, ready_o, ser_o}), 0);
    rst_n = 1'b1;
    idle(2);
    chk("R2 remote stays low", int'(st_o), 0);
    chk("R2 remote wake low", int'(wake_o), 0);

    send_byte(8'h55);
    chk("R3 other byte ignored", int'(st_o), 0);
    write_reg(4'd4, 8'h00);
    chk("R5 write in low power ignored", int'(pd_o), 1);

    send_byte(8'hDB);
    chk("R3 wake byte to settle", int'(st_o), 1);
    chk("R3 analog wake high", int'(wake_o), 1);
    write_reg(4'd4, 8'h00);
    chk("R5 write in settle ignored pd", int'(pd_o), 1);
    chk("R5 write in settle ignored st", int'(st_o), 1);
    idle(SET - 2);
    chk("R4 ready low at last settle cycle", int'(ready_o), 0);
    idle(1);
    chk("R4 ready high after settle", int'(ready_o), 1);
    chk("R4 config window state", int'(st_o), 2);
    idle(WIN - SET - 1);
    chk("R6 window still open at last cycle", int'(st_o), 2);
    idle(1);
    chk("R6 timeout to low power", int'(st_o), 0);
    chk("R6 timeout pd set", int'(pd_o), 1);

    send_byte(8'hDB);
    idle(SET);
    chk("R4 second wake config", int'(st_o), 2);
    write_reg(4'd5, 8'h00);
    chk("R5 other address ignored", int'(st_o), 2);
    chk("R5 other address pd", int'(pd_o), 1);
    write_reg(4'd4, 8'h00);
    chk("R7 clear pd opens channel", int'(st_o), 3);
    chk("R7 pd cleared", int'(pd_o), 0);
    idle(WIN + 50);
    chk("R7 no timeout while seren 0", int'(st_o), 3);
    send_byte(8'hDB);
    chk("R12 wake byte ignored when open", int'(st_o), 3);

    lock = 1'b1;
    idle(LOCK + 3);
    chk("R9 no serialize while seren 0", int'(st_o), 3);
    write_reg(4'd4, 8'h08);
    chk("R9 seren written", int'(se_o), 1);
    chk("R9 still open on write edge", int'(st_o), 3);
    idle(1);
    chk("R9 serializing", int'(st_o), 4);
    chk("R10 ser active", int'(ser_o), 1);
    chk("R10 ready low in ser", int'(ready_o), 0);
    write_reg(4'd4, 8'h10);
    chk("R10 write in ser ignored st", int'(st_o), 4);
    chk("R5 write in ser ignored pd", int'(pd_o), 0);
    lock = 1'b0;
    idle(1);
    chk("R10 lock loss reopens", int'(st_o), 3);

    lock = 1'b1; idle(5);
    lock = 1'b0; idle(1);
    lock = 1'b1;
    idle(LOCK);
    chk("R9 glitch restarts count", int'(st_o), 3);
    idle(1);
    chk("R9 serialize after full count", int'(st_o), 4);
    lock = 1'b0;
    idle(1);
    write_reg(4'd4, 8'h10);
    chk("R8 pd write to low power", int'(st_o), 0);
    chk("R8 seren cleared", int'(se_o), 0);

    send_byte(8'hDB);
    idle(WIN - 1);
    chk("R6 last window cycle", int'(st_o), 2);
    write_reg(4'd4, 8'h00);
    chk("R6 clear on final edge counts", int'(st_o), 3);

    send_byte(8'hDB);
    write_reg(4'd4, 8'h10);
    chk("R8 pd write from open", int'(st_o), 0);
    send_byte(8'hDB);
    idle(SET);
    write_reg(4'd4, 8'h18);
    chk("R8 pd write from config", int'(st_o), 0);
    chk("R8 pd set from config", int'(pd_o), 1);

    rst_n = 1'b0; strap = 1'b0; lock = 1'b0;
    idle(2);
    chk("R1 local reset state", int'(st_o), 0);
    rst_n = 1'b1;
    idle(1);
    chk("R1 local boot open", int'(st_o), 3);
    chk("R1 local pd", int'(pd_o), 0);
    chk("R1 local seren", int'(se_o), 1);
    lock = 1'b1;
    idle(LOCK);
    chk("R9 local waits lock count", int'(st_o), 3);
    idle(1);
    chk("R9 local serializing", int'(st_o), 4);

    idle(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule